// File: doc/BRIEF.md
# AXI Single-Transaction Admission Filter

This block stands in front of a memory backend that can only run one transfer at a time. On its AXI4 subordinate side it takes write requests (address, data and response channels) and read requests (address and data channels). Each request is screened as it is accepted. Requests that use a feature the backend cannot serve are answered locally with an error response and never reach the backend. A legal request is turned into one simple command holding the start address, AXI beat count, transfer size and direction.

The block admits exactly one transaction at a time, whatever its ID or direction. It accepts nothing further until the current transaction has fully completed on the AXI side. For a write, that is the write-response handshake. For a read, it is the handshake of the beat that carries the last flag. Write data beats pass straight through to the backend, and read data beats pass straight back, so bursts of any AXI length are streamed without buffering. When a read and a write request arrive in the same cycle, the grant alternates between the two directions.

Top module: `axi_single_admit`

## Requirements
- R1: After reset, the write-response valid, read valid and command valid outputs are low, and no address-ready output is high while no request is valid.
- R2: At most one transaction is in flight. After an address handshake on either channel, no further address handshake takes place until the write response (B) handshake or the read (R) handshake that carries the last flag. The two address-ready outputs are never high in the same cycle.
- R3: A request whose burst type is not incrementing is unsupported. The incrementing code is 2'b01; fixed (2'b00) and wrap (2'b10) bursts are unsupported. An unsupported request produces no backend command.
- R4: A write request with a non-zero 6-bit atomic operation field is unsupported and produces no backend command.
- R5: A request with size code 0 (one byte) may start at any address. A request with a larger size code and address bit 0 set is unsupported.
- R6: Size codes from 0 up to log2(DATA_W/8) are accepted. A larger size code is unsupported.
- R7: An unsupported write accepts all of its W beats, up to and including the one with the last flag, forwards none of them, and then returns exactly one B response with resp = SLVERR (2'b10) and the request's ID.
- R8: An unsupported read returns AWLEN-style len+1 R beats. Each beat carries resp = SLVERR, zero data and the request's ID, and the last flag is set on the final beat only.
- R9: A legal request produces one command whose address, len, size and direction (1 = write) equal the request. The command stays valid with unchanged fields until the backend's ready handshake.
- R10: For a legal write, every W beat reaches the backend with unchanged data, strobes and last flag. B returns the request's ID, with resp OKAY (2'b00) if the backend's error flag is low and SLVERR otherwise.
- R11: For a legal read, the backend's beats are returned on R with unchanged data and last flag and with the request's ID. Resp is OKAY when the backend's error flag is low and SLVERR when it is high.
- R12: When both address channels hold a valid request in the same cycle, the grant goes to the direction opposite the most recently accepted request. After reset, a write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_aw_valid | input | 1 | Write address valid |
| s_aw_ready | output | 1 | Write address ready |
| s_aw_id | input | ID_W | Write ID |
| s_aw_addr | input | ADDR_W | Write start address |
| s_aw_len | input | 8 | Write beats minus one |
| s_aw_size | input | 3 | Write size code |
| s_aw_burst | input | 2 | Write burst type |
| s_aw_atop | input | 6 | Atomic operation field |
| s_w_valid | input | 1 | Write data valid |
| s_w_ready | output | 1 | Write data ready |
| s_w_data | input | DATA_W | Write data |
| s_w_strb | input | DATA_W/8 | Write byte strobes |
| s_w_last | input | 1 | Last write beat |
| s_b_valid | output | 1 | Write response valid |
| s_b_ready | input | 1 | Write response ready |
| s_b_id | output | ID_W | Write response ID |
| s_b_resp | output | 2 | Write response code |
| s_ar_valid | input | 1 | Read address valid |
| s_ar_ready | output | 1 | Read address ready |
| s_ar_id | input | ID_W | Read ID |
| s_ar_addr | input | ADDR_W | Read start address |
| s_ar_len | input | 8 | Read beats minus one |
| s_ar_size | input | 3 | Read size code |
| s_ar_burst | input | 2 | Read burst type |
| s_r_valid | output | 1 | Read data valid |
| s_r_ready | input | 1 | Read data ready |
| s_r_id | output | ID_W | Read ID |
| s_r_data | output | DATA_W | Read data |
| s_r_resp | output | 2 | Read response code |
| s_r_last | output | 1 | Last read beat |
| cmd_valid | output | 1 | Backend command valid |
| cmd_ready | input | 1 | Backend command ready |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_len | output | 8 | Command beats minus one |
| cmd_size | output | 3 | Command size code |
| cmd_write | output | 1 | Command direction, 1 = write |
| bw_valid | output | 1 | Backend write data valid |
| bw_ready | input | 1 | Backend write data ready |
| bw_data | output | DATA_W | Backend write data |
| bw_strb | output | DATA_W/8 | Backend write strobes |
| bw_last | output | 1 | Backend last write beat |
| bb_valid | input | 1 | Backend write done valid |
| bb_ready | output | 1 | Backend write done ready |
| bb_err | input | 1 | Backend write error |
| br_valid | input | 1 | Backend read data valid |
| br_ready | output | 1 | Backend read data ready |
| br_data | input | DATA_W | Backend read data |
| br_err | input | 1 | Backend read error |
| br_last | input | 1 | Backend last read beat |

## Verification
The hardest case to reach is a read and a write address presented in the very same cycle, because the outcome depends on which direction was accepted last. The stimulus launches a write sequence and a read sequence in parallel, so both address valids rise on one edge. It repeats this after a known history, and a behavioural model tracks the last accepted direction and predicts the winner. The backend's command-ready and write-ready are driven from a pseudo-random sequence, so the command is often held for several cycles. The model compares the held fields on every clock and checks each issued command against a queue built from the legal requests it saw accepted.

// File: rtl/axi_adm_pkg.sv
package axi_adm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WFWD,
    ST_WRSP,
    ST_WDRAIN,
    ST_WERR,
    ST_RFWD,
    ST_RERR
  } adm_state_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
  localparam logic [1:0] BURST_INCR  = 2'b01;

endpackage

// File: rtl/axi_adm_screen.sv
module axi_adm_screen #(
  parameter int SIZE_MAX = 3
) (
  input  logic       addr_lsb,
  input  logic [2:0] size,
  input  logic [1:0] burst,
  input  logic [5:0] atop,
  output logic       ok
);
  import axi_adm_pkg::*;

  localparam logic [2:0] SMAX = 3'(SIZE_MAX);

  logic burst_ok;
  logic atop_ok;
  logic size_ok;
  logic align_ok;

  always_comb begin
    burst_ok = (burst == BURST_INCR);
    atop_ok  = (atop == 6'd0);
    size_ok  = (size <= SMAX);
    align_ok = (size == 3'd0) || !addr_lsb;
    ok       = burst_ok && atop_ok && size_ok && align_ok;
  end

endmodule

// File: rtl/axi_adm_arb.sv
module axi_adm_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_w,
  input  logic req_r,
  output logic gnt_w,
  output logic gnt_r
);

  logic last_w_q;
  logic last_w_d;
  logic upd;

  always_comb begin
    gnt_w    = en && req_w && (!req_r || !last_w_q);
    gnt_r    = en && req_r && !gnt_w;
    upd      = gnt_w || gnt_r;
    last_w_d = last_w_q;
    if (upd) last_w_d = gnt_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_w_q <= 1'b0;
    end else if (upd) begin
      last_w_q <= last_w_d;
    end
  end

endmodule

// File: rtl/axi_single_admit.sv
module axi_single_admit #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_aw_valid,
  output logic                s_aw_ready,
  input  logic [ID_W-1:0]     s_aw_id,
  input  logic [ADDR_W-1:0]   s_aw_addr,
  input  logic [7:0]          s_aw_len,
  input  logic [2:0]          s_aw_size,
  input  logic [1:0]          s_aw_burst,
  input  logic [5:0]          s_aw_atop,
  input  logic                s_w_valid,
  output logic                s_w_ready,
  input  logic [DATA_W-1:0]   s_w_data,
  input  logic [DATA_W/8-1:0] s_w_strb,
  input  logic                s_w_last,
  output logic                s_b_valid,
  input  logic                s_b_ready,
  output logic [ID_W-1:0]     s_b_id,
  output logic [1:0]          s_b_resp,
  input  logic                s_ar_valid,
  output logic                s_ar_ready,
  input  logic [ID_W-1:0]     s_ar_id,
  input  logic [ADDR_W-1:0]   s_ar_addr,
  input  logic [7:0]          s_ar_len,
  input  logic [2:0]          s_ar_size,
  input  logic [1:0]          s_ar_burst,
  output logic                s_r_valid,
  input  logic                s_r_ready,
  output logic [ID_W-1:0]     s_r_id,
  output logic [DATA_W-1:0]   s_r_data,
  output logic [1:0]          s_r_resp,
  output logic                s_r_last,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [7:0]          cmd_len,
  output logic [2:0]          cmd_size,
  output logic                cmd_write,
  output logic                bw_valid,
  input  logic                bw_ready,
  output logic [DATA_W-1:0]   bw_data,
  output logic [DATA_W/8-1:0] bw_strb,
  output logic                bw_last,
  input  logic                bb_valid,
  output logic                bb_ready,
  input  logic                bb_err,
  input  logic                br_valid,
  output logic                br_ready,
  input  logic [DATA_W-1:0]   br_data,
  input  logic                br_err,
  input  logic                br_last
);
  import axi_adm_pkg::*;

  localparam int STRB_W   = DATA_W / 8;
  localparam int SIZE_MAX = $clog2(STRB_W);

  adm_state_e        state_q, state_d;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        len_q;
  logic [2:0]        size_q;
  logic              write_q;
  logic [7:0]        cnt_q, cnt_d;
  logic              cnt_en;
  logic              gnt_w, gnt_r, load;
  logic              w_ok, r_ok;

  // request screening, one instance per address channel
  axi_adm_screen #(.SIZE_MAX(SIZE_MAX)) u_scr_w (
    .addr_lsb (s_aw_addr[0]),
    .size     (s_aw_size),
    .burst    (s_aw_burst),
    .atop     (s_aw_atop),
    .ok       (w_ok)
  );

  axi_adm_screen #(.SIZE_MAX(SIZE_MAX)) u_scr_r (
    .addr_lsb (s_ar_addr[0]),
    .size     (s_ar_size),
    .burst    (s_ar_burst),
    .atop     (6'd0),
    .ok       (r_ok)
  );

  axi_adm_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state_q == ST_IDLE),
    .req_w (s_aw_valid),
    .req_r (s_ar_valid),
    .gnt_w (gnt_w),
    .gnt_r (gnt_r)
  );

  assign s_aw_ready = gnt_w;
  assign s_ar_ready = gnt_r;
  assign load       = gnt_w || gnt_r;

  assign cmd_addr  = addr_q;
  assign cmd_len   = len_q;
  assign cmd_size  = size_q;
  assign cmd_write = write_q;
  assign s_b_id    = id_q;
  assign s_r_id    = id_q;
  assign bw_data   = s_w_data;
  assign bw_strb   = s_w_strb;
  assign bw_last   = s_w_last;

  // next state and channel steering
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    cmd_valid = 1'b0;
    s_w_ready = 1'b0;
    bw_valid  = 1'b0;
    s_b_valid = 1'b0;
    s_b_resp  = RESP_OKAY;
    bb_ready  = 1'b0;
    s_r_valid = 1'b0;
    s_r_data  = '0;
    s_r_resp  = RESP_OKAY;
    s_r_last  = 1'b0;
    br_ready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d  = 8'd0;
        cnt_en = 1'b1;
        if (gnt_w)      state_d = w_ok ? ST_CMD : ST_WDRAIN;
        else if (gnt_r) state_d = r_ok ? ST_CMD : ST_RERR;
      end
      ST_CMD: begin
        cmd_valid = 1'b1;
        if (cmd_ready) state_d = write_q ? ST_WFWD : ST_RFWD;
      end
      ST_WFWD: begin
        bw_valid  = s_w_valid;
        s_w_ready = bw_ready;
        if (s_w_valid && bw_ready && s_w_last) state_d = ST_WRSP;
      end
      ST_WRSP: begin
        s_b_valid = bb_valid;
        bb_ready  = s_b_ready;
        s_b_resp  = bb_err ? RESP_SLVERR : RESP_OKAY;
        if (bb_valid && s_b_ready) state_d = ST_IDLE;
      end
      ST_WDRAIN: begin
        s_w_ready = 1'b1;
        if (s_w_valid && s_w_last) state_d = ST_WERR;
      end
      ST_WERR: begin
        s_b_valid = 1'b1;
        s_b_resp  = RESP_SLVERR;
        if (s_b_ready) state_d = ST_IDLE;
      end
      ST_RFWD: begin
        s_r_valid = br_valid;
        br_ready  = s_r_ready;
        s_r_data  = br_data;
        s_r_last  = br_last;
        s_r_resp  = br_err ? RESP_SLVERR : RESP_OKAY;
        if (br_valid && s_r_ready && br_last) state_d = ST_IDLE;
      end
      ST_RERR: begin
        s_r_valid = 1'b1;
        s_r_resp  = RESP_SLVERR;
        s_r_last  = (cnt_q == len_q);
        if (s_r_ready) begin
          if (s_r_last) begin
            state_d = ST_IDLE;
          end else begin
            cnt_d  = cnt_q + 8'd1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 8'd0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= '0;
      addr_q  <= '0;
      len_q   <= 8'd0;
      size_q  <= 3'd0;
      write_q <= 1'b0;
    end else if (load) begin
      id_q    <= gnt_w ? s_aw_id   : s_ar_id;
      addr_q  <= gnt_w ? s_aw_addr : s_ar_addr;
      len_q   <= gnt_w ? s_aw_len  : s_ar_len;
      size_q  <= gnt_w ? s_aw_size : s_ar_size;
      write_q <= gnt_w;
    end
  end

  // R2: an accepted request blocks any address handshake in the next cycle
  a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_aw_valid && s_aw_ready) || (s_ar_valid && s_ar_ready)) |=> (!s_aw_ready && !s_ar_ready));

  // R9: command held unchanged until the backend takes it
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                   && $stable(cmd_size) && $stable(cmd_write)));

  // R7: a single B response per write
  a_r7_single_b: assert property (@(posedge clk) disable iff (!rst_n)
    (s_b_valid && s_b_ready) |=> !s_b_valid);

  // R8: an error beat waiting for ready keeps its last flag and response
  a_r8_err_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RERR && !s_r_ready) |=> (s_r_valid && $stable(s_r_last) && $stable(s_r_resp)));

endmodule

// File: tb/axi_single_admit_test.sv
module axi_single_admit_test;
  localparam int CLK_P = 10;
  localparam int DW = 64;
  localparam int AW = 32;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          aw_valid = 0, aw_ready;
  logic [IW-1:0] aw_id = 0;
  logic [AW-1:0] aw_addr = 0;
  logic [7:0]    aw_len = 0;
  logic [2:0]    aw_size = 0;
  logic [1:0]    aw_burst = 0;
  logic [5:0]    aw_atop = 0;
  logic          w_valid = 0, w_ready, w_last = 0;
  logic [DW-1:0] w_data = 0;
  logic [DW/8-1:0] w_strb = '1;
  logic          b_valid, b_ready = 0;
  logic [IW-1:0] b_id;
  logic [1:0]    b_resp;
  logic          ar_valid = 0, ar_ready;
  logic [IW-1:0] ar_id = 0;
  logic [AW-1:0] ar_addr = 0;
  logic [7:0]    ar_len = 0;
  logic [2:0]    ar_size = 0;
  logic [1:0]    ar_burst = 0;
  logic          r_valid, r_ready = 0, r_last;
  logic [IW-1:0] r_id;
  logic [DW-1:0] r_data;
  logic [1:0]    r_resp;
  logic          cmd_valid, cmd_ready, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [7:0]    cmd_len;
  logic [2:0]    cmd_size;
  logic          bw_valid, bw_ready, bw_last;
  logic [DW-1:0] bw_data;
  logic [DW/8-1:0] bw_strb;
  logic          bb_valid = 0, bb_ready, bb_err = 0;
  logic          br_valid = 0, br_ready, br_err = 0, br_last = 0;
  logic [DW-1:0] br_data = 0;

  logic [7:0] lf = 8'h5A;
  assign cmd_ready = lf[0];
  assign bw_ready  = lf[1] | lf[2];

  axi_single_admit #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW)) uut (
    .clk(clk), .rst_n(rst_n),
    .s_aw_valid(aw_valid), .s_aw_ready(aw_ready), .s_aw_id(aw_id), .s_aw_addr(aw_addr),
    .s_aw_len(aw_len), .s_aw_size(aw_size), .s_aw_burst(aw_burst), .s_aw_atop(aw_atop),
    .s_w_valid(w_valid), .s_w_ready(w_ready), .s_w_data(w_data), .s_w_strb(w_strb), .s_w_last(w_last),
    .s_b_valid(b_valid), .s_b_ready(b_ready), .s_b_id(b_id), .s_b_resp(b_resp),
    .s_ar_valid(ar_valid), .s_ar_ready(ar_ready), .s_ar_id(ar_id), .s_ar_addr(ar_addr),
    .s_ar_len(ar_len), .s_ar_size(ar_size), .s_ar_burst(ar_burst),
    .s_r_valid(r_valid), .s_r_ready(r_ready), .s_r_id(r_id), .s_r_data(r_data),
    .s_r_resp(r_resp), .s_r_last(r_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_size(cmd_size), .cmd_write(cmd_write),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_data(bw_data), .bw_strb(bw_strb), .bw_last(bw_last),
    .bb_valid(bb_valid), .bb_ready(bb_ready), .bb_err(bb_err),
    .br_valid(br_valid), .br_ready(br_ready), .br_data(br_data), .br_err(br_err), .br_last(br_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] wpat(input logic [IW-1:0] id, input int beat);
    logic [31:0] v;
    v = 32'hA500_0000 ^ (32'(id) << 12) ^ 32'(beat);
    return {DW/32{v}};
  endfunction

  function automatic logic [DW-1:0] rpat(input logic [AW-1:0] a, input int beat);
    logic [31:0] v;
    v = a + 32'(beat) * 32'h0101;
    return {DW/32{v}};
  endfunction

  function automatic bit legal(input bit wr, input logic [AW-1:0] a, input logic [2:0] sz,
                               input logic [1:0] bu, input logic [5:0] at);
    return (bu == 2'b01) && (!wr || at == 6'd0) && (sz <= 3'd3) && (sz == 3'd0 || !a[0]);
  endfunction

  // behavioural reference state
  int outstanding = 0;
  bit last_was_w = 0;
  logic [AW+8+3:0] q_cmd[$];
  bit hold_prev = 0;
  logic [AW+8+3:0] hold_val = '0;
  logic [IW-1:0] cur_wid = 0;
  int bw_cnt = 0;
  bit g_berr = 0, g_rerr = 0;

  initial forever begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  end

  // per-clock model comparison
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (aw_ready && ar_ready) chk("R2", "both address readies", 1, 0);
      if (aw_valid && ar_valid && (aw_ready || ar_ready))
        chk("R12", "write wins contention", 64'(aw_ready), 64'(!last_was_w));
      if (hold_prev) begin
        chk("R9", "cmd held valid", 64'(cmd_valid), 1);
        chk("R9", "cmd fields stable", 64'({cmd_addr, cmd_len, cmd_size, cmd_write}), 64'(hold_val));
      end
      hold_prev = cmd_valid && !cmd_ready;
      hold_val  = {cmd_addr, cmd_len, cmd_size, cmd_write};
      if (aw_valid && aw_ready) begin
        chk("R2", "accept while busy (aw)", 64'(outstanding), 0);
        outstanding = 1; last_was_w = 1;
        if (legal(1, aw_addr, aw_size, aw_burst, aw_atop))
          q_cmd.push_back({aw_addr, aw_len, aw_size, 1'b1});
      end
      if (ar_valid && ar_ready) begin
        chk("R2", "accept while busy (ar)", 64'(outstanding), 0);
        outstanding = 1; last_was_w = 0;
        if (legal(0, ar_addr, ar_size, ar_burst, 6'd0))
          q_cmd.push_back({ar_addr, ar_len, ar_size, 1'b0});
      end
      if (cmd_valid && cmd_ready) begin
        if (q_cmd.size() == 0) chk("R3", "unexpected command", 64'({cmd_addr, cmd_len, cmd_size, cmd_write}), 0);
        else chk("R9", "command matches request", 64'({cmd_addr, cmd_len, cmd_size, cmd_write}), 64'(q_cmd.pop_front()));
      end
      if (bw_valid && bw_ready) begin
        chk("R10", "forwarded write data", bw_data, wpat(cur_wid, bw_cnt));
        bw_cnt++;
      end
      if (b_valid && b_ready) outstanding = 0;
      if (r_valid && r_ready && r_last) outstanding = 0;
    end
  end

  // backend model
  initial forever begin
    logic c_wr;
    logic [AW-1:0] c_addr;
    logic [7:0] c_len;
    @(negedge clk);
    if (rst_n && cmd_valid && cmd_ready) begin
      c_wr = cmd_write; c_addr = cmd_addr; c_len = cmd_len;
      @(posedge clk); #1;
      if (c_wr) begin
        do @(negedge clk); while (!(bw_valid && bw_ready && bw_last));
        @(posedge clk); #1;
        bb_valid = 1; bb_err = g_berr;
        do @(negedge clk); while (!bb_ready);
        @(posedge clk); #1;
        bb_valid = 0; bb_err = 0;
      end else begin
        for (int b = 0; b <= int'(c_len); b++) begin
          br_valid = 1; br_data = rpat(c_addr, b); br_last = (b == int'(c_len)); br_err = g_rerr;
          do @(negedge clk); while (!br_ready);
          @(posedge clk); #1;
        end
        br_valid = 0; br_last = 0; br_err = 0;
      end
    end
  end

  task automatic do_write(input logic [IW-1:0] id, input logic [AW-1:0] a, input logic [7:0] len,
                          input logic [2:0] sz, input logic [1:0] bu, input logic [5:0] at,
                          input bit berr, input string req);
    bit ok;
    ok = legal(1, a, sz, bu, at);
    g_berr = berr; cur_wid = id; bw_cnt = 0;
    @(posedge clk); #1;
    aw_valid = 1; aw_id = id; aw_addr = a; aw_len = len; aw_size = sz; aw_burst = bu; aw_atop = at;
    do @(negedge clk); while (!aw_ready);
    @(posedge clk); #1;
    aw_valid = 0;
    for (int b = 0; b <= int'(len); b++) begin
      w_valid = 1; w_data = wpat(id, b); w_last = (b == int'(len));
      do @(negedge clk); while (!w_ready);
      @(posedge clk); #1;
    end
    w_valid = 0; w_last = 0;
    b_ready = 1;
    do @(negedge clk); while (!b_valid);
    chk(req, "B id", 64'(b_id), 64'(id));
    chk(req, "B resp", 64'(b_resp), (ok && !berr) ? 64'd0 : 64'd2);
    @(posedge clk); #1;
    b_ready = 0;
    chk(ok ? "R10" : "R7", "beats reaching backend", 64'(bw_cnt), ok ? 64'(int'(len) + 1) : 64'd0);
  endtask

  task automatic do_read(input logic [IW-1:0] id, input logic [AW-1:0] a, input logic [7:0] len,
                         input logic [2:0] sz, input logic [1:0] bu, input bit rerr, input string req);
    bit ok;
    ok = legal(0, a, sz, bu, 6'd0);
    g_rerr = rerr;
    @(posedge clk); #1;
    ar_valid = 1; ar_id = id; ar_addr = a; ar_len = len; ar_size = sz; ar_burst = bu;
    do @(negedge clk); while (!ar_ready);
    @(posedge clk); #1;
    ar_valid = 0;
    r_ready = 1;
    for (int b = 0; b <= int'(len); b++) begin
      do @(negedge clk); while (!r_valid);
      chk(req, "R id", 64'(r_id), 64'(id));
      chk(req, "R resp", 64'(r_resp), (ok && !rerr) ? 64'd0 : 64'd2);
      chk(req, "R last", 64'(r_last), 64'(b == int'(len)));
      chk(req, "R data", r_data, ok ? rpat(a, b) : '0);
      @(posedge clk); #1;
    end
    r_ready = 0;
    @(negedge clk);
    chk(ok ? "R11" : "R8", "no beat after last", 64'(r_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "b_valid after reset", 64'(b_valid), 0);
    chk("R1", "r_valid after reset", 64'(r_valid), 0);
    chk("R1", "cmd_valid after reset", 64'(cmd_valid), 0);
    chk("R1", "aw_ready idle", 64'(aw_ready), 0);
    chk("R1", "ar_ready idle", 64'(ar_ready), 0);

    do_write(4'h1, 32'h100, 8'd3, 3'd3, 2'b01, 6'd0, 0, "R10");
    do_write(4'h2, 32'h101, 8'd0, 3'd0, 2'b01, 6'd0, 0, "R5");
    do_write(4'h3, 32'h103, 8'd2, 3'd1, 2'b01, 6'd0, 0, "R5");
    do_write(4'h4, 32'h200, 8'd1, 3'd2, 2'b01, 6'h20, 0, "R4");
    do_write(4'h5, 32'h200, 8'd2, 3'd2, 2'b00, 6'd0, 0, "R3");
    do_write(4'h6, 32'h200, 8'd0, 3'd4, 2'b01, 6'd0, 0, "R6");
    do_write(4'h7, 32'h300, 8'd1, 3'd3, 2'b01, 6'd0, 1, "R10");
    do_read (4'h8, 32'h400, 8'd4, 3'd2, 2'b01, 0, "R11");
    do_read (4'h9, 32'h400, 8'd3, 3'd2, 2'b10, 0, "R8");
    do_read (4'hA, 32'h011, 8'd1, 3'd3, 2'b01, 0, "R5");
    do_read (4'hB, 32'h033, 8'd0, 3'd0, 2'b01, 0, "R5");
    do_read (4'hC, 32'h500, 8'd2, 3'd3, 2'b01, 1, "R11");
    do_read (4'hD, 32'h600, 8'd0, 3'd5, 2'b01, 0, "R6");
    do_write(4'hE, 32'h1000, 8'd255, 3'd3, 2'b01, 6'd0, 0, "R10");
    fork
      do_write(4'h3, 32'h700, 8'd2, 3'd3, 2'b01, 6'd0, 0, "R12");
      do_read (4'h5, 32'h800, 8'd2, 3'd3, 2'b01, 0, "R12");
    join
    fork
      do_write(4'h6, 32'h900, 8'd1, 3'd1, 2'b01, 6'd0, 0, "R12");
      do_read (4'h7, 32'hA00, 8'd1, 3'd1, 2'b01, 0, "R12");
    join
    repeat (4) @(negedge clk);
    chk("R9", "commands left pending", 64'(q_cmd.size()), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule